// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous host and an external, unclocked static RAM holding 256K words of 16 bits. The host issues one transfer at a time with a single-cycle request carrying a read/write flag, an 18-bit word address, 16 bits of write data and two lane enables. The controller then runs the memory's strobes through a fixed sequence and answers with a one-clock completion pulse, together with the read word for reads.

All memory-side strobes are active low: chip select, output enable, write enable and one select per byte lane. The data bus is shared and bidirectional. Each phase of the sequence lasts a whole number of clocks. These counts are derived at elaboration from the clock period and the memory's access time, write pulse width, data setup and write cycle time, so one netlist can serve a different clock by changing one parameter.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and in every cycle with no transfer in flight, all five strobes are high, done is low and the controller leaves the data bus undriven. After reset, rdata is zero.
- R2: A read holds chip select and output enable low, with write enable high, for RD_CYC cycles. Bit 0 of the lane enable maps to the lower lane (data bits 7:0, strobe sram_lb_n) and bit 1 maps to the upper lane (bits 15:8, sram_ub_n). rdata takes the bus value on the last cycle of that window, and lanes that are not enabled read as zero.
- R3: A write runs in three phases. The first is one setup cycle with chip select low and write enable high. The second is WP_CYC cycles with write enable low and the selected lane strobes low. The third is one closing cycle with chip select still low and write enable high. Only the enabled lanes of the addressed word change.
- R4: The memory address changes only in the cycle after one in which chip select was high. It does not change while chip select stays low from one cycle to the next, so it never moves during a write pulse.
- R5: Output enable and write enable are never low together. The controller drives the data bus only while output enable is high.
- R6: A write accepted directly after a read gets one extra idle cycle, with every strobe high and the bus undriven, before its setup phase. This adds one cycle to its completion latency.
- R7: Each accepted request produces exactly one done pulse of one clock. It comes RD_CYC clocks after the accepting edge for a read and WP_CYC+2 clocks after it for a write, plus R6's extra cycle where that applies.
- R8: A request presented while a transfer is in flight is dropped. It changes no memory word and produces no done pulse.
- R9: With both lane enables zero, neither lane strobe goes low. A read returns zero, a write leaves the word unchanged, and the transfer still completes with a done pulse.
- R10: RD_CYC is the access time divided by the clock period, rounded up, and is at least 1. WP_CYC is the largest of the rounded-up pulse width, the rounded-up data setup time, the rounded-up write cycle time minus 2, and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Single-cycle transfer request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower lane, bit 1 upper lane |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read word, valid from the done pulse on |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper lane select, active low |
| sram_lb_n | output | 1 | Lower lane select, active low |
| sram_addr | output | 18 | Memory word address |
| sram_dq | inout | 16 | Bidirectional memory data bus |

## Verification
The assertions check the bus discipline on every clock. They cover address stability while the chip is selected, write enable never overlapping output enable, the bus being driven only with output enable high and never in the cycle after a read, lane strobes only under chip select, and the single-cycle completion pulse. Only the bench scenarios can show the data-level behaviour: lane-masked merges, requests dropped while busy, the zero result and unchanged word for empty lane masks, the extra turnaround cycle in the latency of a write that follows a read, and the phase lengths taken from the timing parameters.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WCLOSE
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } xfer_t;

    typedef struct packed {
        logic             cs_n;
        logic             oe_n;
        logic             we_n;
        logic [LANES-1:0] lane_n;
        logic             drive;
    } pins_t;

    function automatic int cycles_for(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int pulse_cycles(input int wp_ps, input int ds_ps,
                                        input int wc_ps, input int period_ps);
        int c;
        c = cycles_for(wp_ps, period_ps);
        if (cycles_for(ds_ps, period_ps) > c) c = cycles_for(ds_ps, period_ps);
        if (cycles_for(wc_ps, period_ps) - 2 > c) c = cycles_for(wc_ps, period_ps) - 2;
        return c;
    endfunction

endpackage

// File: rtl/asram_ctrl_seq.sv
module asram_ctrl_seq
    import asram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 1,
    parameter int WP_CYC = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_wr,
    output phase_e phase,
    output logic   accept,
    output logic   capture,
    output logic   done
);

    localparam int MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e           st;
    logic [CNT_W-1:0] cnt;
    logic             after_read;

    assign phase   = st;
    assign accept  = (st == ST_IDLE) && req_valid;
    assign capture = (st == ST_READ) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            after_read <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!req_wr) begin
                            st         <= ST_READ;
                            cnt        <= CNT_W'(RD_CYC - 1);
                            after_read <= 1'b1;
                        end else begin
                            st         <= after_read ? ST_TURN : ST_WSETUP;
                            after_read <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt == '0) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TURN: st <= ST_WSETUP;
                ST_WSETUP: begin
                    st  <= ST_WPULSE;
                    cnt <= CNT_W'(WP_CYC - 1);
                end
                ST_WPULSE: begin
                    if (cnt == '0) st <= ST_WCLOSE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_WCLOSE: begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/asram_ctrl_strobe.sv
module asram_ctrl_strobe
    import asram_ctrl_pkg::*;
(
    input  phase_e           phase,
    input  logic [LANES-1:0] be,
    output pins_t            pins
);

    always_comb begin
        pins.cs_n   = 1'b1;
        pins.oe_n   = 1'b1;
        pins.we_n   = 1'b1;
        pins.lane_n = '1;
        pins.drive  = 1'b0;
        case (phase)
            ST_READ: begin
                pins.cs_n   = 1'b0;
                pins.oe_n   = 1'b0;
                pins.lane_n = ~be;
            end
            ST_WSETUP, ST_WCLOSE: begin
                pins.cs_n  = 1'b0;
                pins.drive = 1'b1;
            end
            ST_WPULSE: begin
                pins.cs_n   = 1'b0;
                pins.we_n   = 1'b0;
                pins.lane_n = ~be;
                pins.drive  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/asram_ctrl_dpath.sv
module asram_ctrl_dpath
    import asram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  xfer_t             xfer_in,
    input  logic [DATA_W-1:0] bus_in,
    output xfer_t             xfer_q,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst)         xfer_q <= '0;
        else if (accept) xfer_q <= xfer_in;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata[i*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rdata[i*LANE_W +: LANE_W] <= xfer_q.be[i] ? bus_in[i*LANE_W +: LANE_W]
                                                          : '0;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int T_ACCESS_PS   = 15000,
    parameter int T_WPULSE_PS   = 10000,
    parameter int T_DSETUP_PS   = 7000,
    parameter int T_WCYCLE_PS   = 15000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int RD_CYC = cycles_for(T_ACCESS_PS, CLK_PERIOD_PS);
    localparam int WP_CYC = pulse_cycles(T_WPULSE_PS, T_DSETUP_PS,
                                         T_WCYCLE_PS, CLK_PERIOD_PS);

    phase_e phase;
    logic   accept;
    logic   capture;
    xfer_t  xfer_in;
    xfer_t  xfer_q;
    pins_t  pins;
    logic   drive_en;

    assign xfer_in = '{wr: req_wr, addr: req_addr, wdata: req_wdata, be: req_be};

    asram_ctrl_seq #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .phase     (phase),
        .accept    (accept),
        .capture   (capture),
        .done      (done)
    );

    asram_ctrl_strobe u_strobe (
        .phase (phase),
        .be    (xfer_q.be),
        .pins  (pins)
    );

    asram_ctrl_dpath u_dpath (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .capture (capture),
        .xfer_in (xfer_in),
        .bus_in  (sram_dq),
        .xfer_q  (xfer_q),
        .rdata   (rdata)
    );

    assign drive_en  = pins.drive;
    assign sram_cs_n = pins.cs_n;
    assign sram_oe_n = pins.oe_n;
    assign sram_we_n = pins.we_n;
    assign sram_lb_n = pins.lane_n[0];
    assign sram_ub_n = pins.lane_n[1];
    assign sram_addr = xfer_q.addr;
    assign sram_dq   = drive_en ? xfer_q.wdata : 'z;

endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker
    import asram_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              ub_n,
    input logic              lb_n,
    input logic [ADDR_W-1:0] addr,
    input logic              drive_en,
    input logic              done
);

    a_r4_addr_moves_deselected: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr) |-> $past(cs_n));

    a_r4_addr_held_selected: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n)) |-> $stable(addr));

    a_r4_addr_hold_after_pulse: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> $stable(addr));

    a_r5_oe_we_exclusive: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n);

    a_r5_drive_needs_oe_high: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> oe_n);

    a_r6_release_after_read: assert property (@(posedge clk) disable iff (rst)
        !$past(oe_n) |-> !drive_en);

    a_r3_write_window: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!cs_n && drive_en));

    a_r9_lanes_under_cs: assert property (@(posedge clk) disable iff (rst)
        (!lb_n || !ub_n) |-> !cs_n);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind asram_ctrl asram_ctrl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (sram_cs_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .ub_n     (sram_ub_n),
    .lb_n     (sram_lb_n),
    .addr     (sram_addr),
    .drive_en (drive_en),
    .done     (done)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

    localparam int PER_PS = 20000;
    localparam int LIMIT  = 20000;

    function automatic int cdiv(input int t);
        int c;
        c = (t + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    int exp_rd;
    int exp_wp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_wr = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        done;
    logic [15:0] rdata;
    logic        sram_cs_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
    logic [17:0] sram_addr;
    wire  [15:0] sram_dq;

    always #10 clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_PS(PER_PS)) u_asram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .done(done), .rdata(rdata), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_addr(sram_addr), .sram_dq(sram_dq)
    );

    function automatic logic [15:0] fill(input int a);
        return 16'(a) ^ 16'hC35A ^ 16'(a >> 3);
    endfunction

    // external memory device model
    logic [15:0] dev_mem [int];
    logic [15:0] dev_word = '0;

    always @(negedge clk) begin
        logic [15:0] w;
        if (!sram_cs_n && !sram_we_n) begin
            w = dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : fill(int'(sram_addr));
            if (!sram_lb_n) w[7:0]  = sram_dq[7:0];
            if (!sram_ub_n) w[15:8] = sram_dq[15:8];
            dev_mem[int'(sram_addr)] = w;
        end
        dev_word = dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : fill(int'(sram_addr));
    end

    assign sram_dq[7:0]  = (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_lb_n) ? dev_word[7:0]  : 8'hzz;
    assign sram_dq[15:8] = (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_ub_n) ? dev_word[15:8] : 8'hzz;

    // stimulus list
    typedef struct {
        bit          wr;
        logic [17:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        bit          force_now;
        string       tag;
    } op_t;

    op_t ops[$];

    task automatic add(input bit wr, input int addr, input int data, input int be,
                       input bit force_now, input string tag);
        op_t o;
        o.wr = wr; o.addr = 18'(addr); o.data = 16'(data); o.be = 2'(be);
        o.force_now = force_now; o.tag = tag;
        ops.push_back(o);
    endtask

    // reference model
    logic [15:0] ref_mem [int];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          m_busy = 0;
    int          m_rem = 0;
    bit          m_last_rd = 0;
    bit          m_turn = 0;
    op_t         m_op;
    op_t         applied;
    logic [15:0] m_exp;
    int          oe_cnt = 0;
    int          we_cnt = 0;

    function automatic logic [15:0] ref_word(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : fill(a);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        int          cyc;
        int          idle;
        bit          exp_done;
        logic [17:0] prev_addr;
        logic        prev_cs_n;
        logic [15:0] w;

        exp_rd = cdiv(15000);
        exp_wp = cdiv(10000);
        if (cdiv(7000) > exp_wp) exp_wp = cdiv(7000);
        if (cdiv(15000) - 2 > exp_wp) exp_wp = cdiv(15000) - 2;

        repeat (3) @(negedge clk);
        check(sram_cs_n && sram_oe_n && sram_we_n && sram_ub_n && sram_lb_n,
              "R1", "strobes in reset",
              {sram_cs_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n}, 5'h1f);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(rdata == 16'h0, "R1", "rdata in reset", rdata, 0);
        rst = 1'b0;

        add(1, 'h00010, 'h1234, 3, 0, "R3");
        add(0, 'h00010, 0, 3, 0, "R2");
        add(0, 'h00123, 0, 3, 0, "R2");
        add(1, 'h00010, 'hABCD, 1, 0, "R3");
        add(0, 'h00010, 0, 3, 0, "R3");
        add(1, 'h00010, 'h5577, 2, 0, "R3");
        add(0, 'h00010, 0, 3, 0, "R3");
        add(0, 'h00010, 0, 1, 0, "R2");
        add(0, 'h00010, 0, 2, 0, "R2");
        add(0, 'h00010, 0, 0, 0, "R9");
        add(1, 'h00010, 'hFFFF, 0, 0, "R9");
        add(0, 'h00010, 0, 3, 0, "R9");
        add(1, 'h00020, 'h0F0F, 3, 0, "R6");
        add(1, 'h00021, 'h1111, 3, 0, "R7");
        add(0, 'h00021, 0, 3, 0, "R7");
        add(1, 'h00030, 'hAAAA, 3, 0, "R8");
        add(1, 'h00030, 'hBBBB, 3, 1, "R8");
        add(0, 'h00030, 0, 3, 1, "R8");
        add(0, 'h00030, 0, 3, 0, "R8");
        add(1, 'h3FFFF, 'hC0DE, 3, 0, "R4");
        add(0, 'h3FFFF, 0, 3, 0, "R4");
        add(0, 'h00000, 0, 3, 0, "R10");
        add(1, 'h00000, 'h4242, 3, 0, "R10");
        for (int i = 0; i < 150; i++)
            add(bit'($urandom_range(0, 1)), $urandom_range(0, 11),
                $urandom_range(0, 65535), $urandom_range(0, 3),
                ($urandom_range(0, 9) == 0), "R7");

        cyc = 0;
        idle = 0;
        prev_addr = sram_addr;
        prev_cs_n = sram_cs_n;
        while (!(ops.size() == 0 && !m_busy && idle > 4) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            exp_done = 0;

            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    exp_done = 1;
                    m_busy = 0;
                end
            end else if (req_valid) begin
                m_busy = 1;
                m_op = applied;
                m_turn = applied.wr && m_last_rd;
                m_last_rd = !applied.wr;
                m_rem = applied.wr ? exp_wp + 2 + (m_turn ? 1 : 0) : exp_rd;
                oe_cnt = 0;
                we_cnt = 0;
                if (applied.wr) begin
                    w = ref_word(int'(applied.addr));
                    if (applied.be[0]) w[7:0]  = applied.data[7:0];
                    if (applied.be[1]) w[15:8] = applied.data[15:8];
                    ref_mem[int'(applied.addr)] = w;
                end else begin
                    w = ref_word(int'(applied.addr));
                    m_exp = {applied.be[1] ? w[15:8] : 8'h00, applied.be[0] ? w[7:0] : 8'h00};
                end
            end

            // completion timing: R6 for a write after a read, otherwise R7
            check(done == exp_done, m_turn ? "R6" : "R7", "done pulse", done, exp_done);
            if (exp_done) begin
                if (!m_op.wr) begin
                    check(rdata == m_exp, m_op.tag, "read data", rdata, m_exp);
                    check(oe_cnt == exp_rd, "R10", "output enable cycles", oe_cnt, exp_rd);
                end else begin
                    check(we_cnt == exp_wp, "R10", "write pulse cycles", we_cnt, exp_wp);
                end
            end
            if (!sram_oe_n) oe_cnt++;
            if (!sram_we_n) we_cnt++;

            if (!m_busy)
                check(sram_cs_n && sram_oe_n && sram_we_n && sram_ub_n && sram_lb_n,
                      "R1", "idle strobes",
                      {sram_cs_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n}, 5'h1f);
            if (!sram_cs_n && !prev_cs_n)
                check(sram_addr == prev_addr, "R4", "address under chip select",
                      sram_addr, prev_addr);
            check(sram_oe_n || sram_we_n, "R5", "oe/we overlap",
                  {sram_oe_n, sram_we_n}, 2'b11);
            if (m_busy && m_op.be == 2'b00)
                check(sram_lb_n && sram_ub_n, "R9", "lane strobes with empty mask",
                      {sram_ub_n, sram_lb_n}, 2'b11);
            prev_addr = sram_addr;
            prev_cs_n = sram_cs_n;

            // drive next request
            req_valid = 1'b0;
            if (ops.size() != 0 && (!m_busy || ops[0].force_now)) begin
                applied   = ops.pop_front();
                req_valid = 1'b1;
                req_wr    = applied.wr;
                req_addr  = applied.addr;
                req_wdata = applied.data;
                req_be    = applied.be;
            end
            if (ops.size() == 0 && !m_busy && !req_valid) idle++;
            else idle = 0;
        end

        if (cyc >= LIMIT) check(0, "R7", "watchdog expired", cyc, LIMIT);

        // final sweep of external memory against the model (R3, R8, R9)
        for (int a = 0; a < 64; a++)
            if (ref_mem.exists(a) || dev_mem.exists(a))
                check((dev_mem.exists(a) ? dev_mem[a] : fill(a)) == ref_word(a), "R8",
                      "memory word", dev_mem.exists(a) ? dev_mem[a] : fill(a), ref_word(a));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule